// File: doc/BRIEF.md
# Moving Edge Detector

This block flags, one bit per pixel, the edges of objects that move in a grayscale video stream. Each pixel is tested twice. First, a 3x3 Sobel gradient of the current frame gives an edge strength, and a threshold turns that into an edge bit. Second, the pixel is compared with the pixel at the same coordinates in the previous frame, and a separate threshold on the absolute difference gives a motion bit. The output bit is the AND of the two, so only edges that lie on moving objects survive. A contour-extraction stage downstream would use the result.

Pixels arrive one per clock, in raster order, with a start-of-frame flag on the first pixel. Within a frame the valid strobe stays high for every pixel; idle cycles are allowed only between frames. The previous frame is held in a synchronous single-port frame store outside the block. As each pixel arrives, the block writes it into the same slot from which that slot's previous-frame value is read, so the store always holds the last frame. Two line buffers, built as one shift chain inside the block, supply the 3x3 window. The output stream follows the input stream at a fixed latency, with its own valid, start-of-frame and end-of-line flags.

Top module: `medge_top`

## Requirements
- R1: outValid, outSof and outEol repeat the input's valid, start-of-frame and last-column (column COLS-1) flags exactly COLS+3 clock cycles after the input pixel is sampled, and outBit belongs to that same pixel.
- R2: A pixel is an edge when |Gx|+|Gy| is strictly greater than edgeThr. Gx is the right column of the 3x3 window weighted 1,2,1 minus the left column weighted the same way. Gy is the bottom row weighted 1,2,1 minus the top row.
- R3: A pixel is moving when the absolute difference between its value and the frame store's value at its address is strictly greater than motionThr.
- R4: outBit is 1 only for a pixel that is both an edge and moving.
- R5: Pixels in row 0, row ROWS-1, column 0 or column COLS-1 produce outBit = 0.
- R6: Every pixel of the first complete frame after reset produces outBit = 0. A frame counts as complete once its pixel at address COLS*ROWS-1 has been accepted.
- R7: For each valid input pixel at (row, col), fsWe is 1, fsAddr is row*COLS+col and fsWrData is the pixel, all in the same cycle. fsRdData must carry the store's old contents of that address one cycle later (read before write).
- R8: While rstN is low, outValid, outSof, outEol and outBit are 0.
- R9: A valid pixel with inSof = 1 is taken as row 0, column 0, whatever the position counters held. This also applies when the previous frame stopped part-way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pixel valid; held high for every pixel of a frame |
| inSof | input | 1 | First pixel of a frame |
| inPix | input | PIX_W | Grayscale pixel of the current frame |
| edgeThr | input | PIX_W+4 | Edge threshold on \|Gx\|+\|Gy\| |
| motionThr | input | PIX_W | Threshold on the frame difference |
| fsAddr | output | ADDR_W | Frame store address (read and write) |
| fsWe | output | 1 | Frame store write enable |
| fsWrData | output | PIX_W | Frame store write data |
| fsRdData | input | PIX_W | Frame store read data, one cycle after fsAddr |
| outValid | output | 1 | Output pixel valid |
| outSof | output | 1 | Output start of frame |
| outEol | output | 1 | Output last pixel of a line |
| outBit | output | 1 | Moving edge bit |

## Verification
Two functions share a single cycle. The frame store write of the arriving pixel and the read of that slot's previous-frame value use one address in the same cycle, so the motion decision depends on read-before-write ordering. The bench's store model follows that ordering, and the bench checks every motion-dependent bit against its own copy of frame k-1. It also drives frames back to back, and a truncated frame followed at once by a new start of frame. This lets the tail of one frame's delayed output overlap the head of the next frame's input and writes. Flags, cycle of arrival and bit value are then judged per pixel against a queue of expected results.

// File: rtl/medge_pkg.sv
package medge_pkg;

  // Strobes from control to datapath, aligned to the stage they qualify
  typedef struct packed {
    logic shiftEn;   // a pixel enters the window chain this cycle
    logic prevOk;    // the frame store holds a complete previous frame
    logic interior;  // the pixel now at the window centre is not on the border
  } medge_strobe_t;

  // Per-pixel tag carried down the fixed-latency line
  typedef struct packed {
    logic valid;
    logic sof;
    logic eol;
    logic interior;
  } medge_tag_t;

endpackage

// File: rtl/medge_sobel.sv
module medge_sobel #(
  parameter int PIX_W = 8,
  parameter int MAG_W = PIX_W + 4
) (
  input  logic [PIX_W-1:0] nw,
  input  logic [PIX_W-1:0] n,
  input  logic [PIX_W-1:0] ne,
  input  logic [PIX_W-1:0] w,
  input  logic [PIX_W-1:0] e,
  input  logic [PIX_W-1:0] sw,
  input  logic [PIX_W-1:0] s,
  input  logic [PIX_W-1:0] se,
  output logic [MAG_W-1:0] mag
);

  localparam int PAD_W = MAG_W - PIX_W;

  function automatic logic signed [MAG_W-1:0] ext(input logic [PIX_W-1:0] p);
    return $signed({{PAD_W{1'b0}}, p});
  endfunction

  logic signed [MAG_W-1:0] gx, gy, ax, ay;

  always_comb begin
    gx = (ext(ne) + (ext(e) <<< 1) + ext(se)) - (ext(nw) + (ext(w) <<< 1) + ext(sw));
    gy = (ext(sw) + (ext(s) <<< 1) + ext(se)) - (ext(nw) + (ext(n) <<< 1) + ext(ne));
    ax = gx[MAG_W-1] ? -gx : gx;
    ay = gy[MAG_W-1] ? -gy : gy;
    mag = $unsigned(ax) + $unsigned(ay);
  end

endmodule

// File: rtl/medge_ctrl.sv
module medge_ctrl
  import medge_pkg::*;
#(
  parameter int COLS   = 320,
  parameter int ROWS   = 240,
  parameter int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  output logic [ADDR_W-1:0] fsAddr,
  output logic              fsWe,
  output medge_strobe_t     strobe,
  output logic              outValid,
  output logic              outSof,
  output logic              outEol
);

  localparam int PIXELS = COLS * ROWS;
  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  // tag stages up to the cycle before the output register
  localparam int DLY    = COLS + 3;

  logic [COL_W-1:0]  colCnt, curCol;
  logic [ROW_W-1:0]  rowCnt, curRow;
  logic [ADDR_W-1:0] addrCnt, curAddr;
  logic              lastCol, lastRow, interiorPos;
  logic              frameSeen, prevOkQ;
  medge_tag_t        inTag;
  medge_tag_t        tagLine [DLY];

  // Position of the pixel on the input this cycle; a start of frame forces origin
  always_comb begin
    curCol      = inSof ? '0 : colCnt;
    curRow      = inSof ? '0 : rowCnt;
    curAddr     = inSof ? '0 : addrCnt;
    lastCol     = (curCol == COL_W'(COLS - 1));
    lastRow     = (curRow == ROW_W'(ROWS - 1));
    interiorPos = (curCol != '0) && !lastCol && (curRow != '0) && !lastRow;
    inTag.valid    = inValid;
    inTag.sof      = inValid && inSof;
    inTag.eol      = inValid && lastCol;
    inTag.interior = inValid && interiorPos;
  end

  assign fsAddr = curAddr;
  assign fsWe   = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt    <= '0;
      rowCnt    <= '0;
      addrCnt   <= '0;
      frameSeen <= 1'b0;
      prevOkQ   <= 1'b0;
    end else begin
      prevOkQ <= frameSeen;
      if (inValid) begin
        colCnt  <= lastCol ? '0 : curCol + 1'b1;
        if (lastCol) rowCnt <= lastRow ? '0 : curRow + 1'b1;
        else         rowCnt <= curRow;
        addrCnt <= (curAddr == ADDR_W'(PIXELS - 1)) ? '0 : curAddr + 1'b1;
        if (curAddr == ADDR_W'(PIXELS - 1)) frameSeen <= 1'b1;
      end
    end
  end

  // Fixed-latency tag line, one stage per cycle
  genvar gi;
  generate
    for (gi = 0; gi < DLY; gi++) begin : g_tag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        tagLine[gi] <= '0;
        else if (gi == 0) tagLine[gi] <= inTag;
        else              tagLine[gi] <= tagLine[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  always_comb begin
    strobe.shiftEn  = tagLine[0].valid;
    strobe.prevOk   = prevOkQ;
    strobe.interior = tagLine[DLY-1].interior;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
    end else begin
      outValid <= tagLine[DLY-1].valid;
      outSof   <= tagLine[DLY-1].sof;
      outEol   <= tagLine[DLY-1].eol;
    end
  end

  // R1
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid);

  // R1
  eol_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEol |-> outValid);

  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsWe |-> ({1'b0, fsAddr} < (ADDR_W + 1)'(PIXELS)));

  // R9
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof) |=> (addrCnt == ADDR_W'(1)));

endmodule

// File: rtl/medge_datapath.sv
module medge_datapath
  import medge_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int COLS  = 320,
  parameter int MAG_W = PIX_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  medge_strobe_t    strobe,
  input  logic [PIX_W-1:0] inPix,
  input  logic [PIX_W-1:0] fsRdData,
  input  logic [PIX_W-1:0] motionThr,
  input  logic [MAG_W-1:0] edgeThr,
  output logic             outBit
);

  localparam int CHAIN = 2 * COLS + 3;
  localparam int ENT_W = PIX_W + 1;   // motion bit on top of the pixel
  localparam int C_MID = COLS + 1;

  logic [PIX_W-1:0] aPix, absDiff;
  logic             moveNow, edgeHit;
  logic [ENT_W-1:0] chain [CHAIN];
  logic [MAG_W-1:0] mag;

  // Stage A: hold the pixel while the store returns its previous value
  always_ff @(posedge clk) aPix <= inPix;

  always_comb begin
    absDiff = (aPix >= fsRdData) ? aPix - fsRdData : fsRdData - aPix;
    moveNow = strobe.prevOk && (absDiff > motionThr);
  end

  // Stage B: two line buffers and the window as one shift chain
  always_ff @(posedge clk) begin
    if (strobe.shiftEn) begin
      chain[0] <= {moveNow, aPix};
      for (int k = 1; k < CHAIN; k++) chain[k] <= chain[k-1];
    end
  end

  medge_sobel #(.PIX_W(PIX_W), .MAG_W(MAG_W)) sobel_i (
    .nw (chain[2*COLS+2][PIX_W-1:0]),
    .n  (chain[2*COLS+1][PIX_W-1:0]),
    .ne (chain[2*COLS][PIX_W-1:0]),
    .w  (chain[COLS+2][PIX_W-1:0]),
    .e  (chain[COLS][PIX_W-1:0]),
    .sw (chain[2][PIX_W-1:0]),
    .s  (chain[1][PIX_W-1:0]),
    .se (chain[0][PIX_W-1:0]),
    .mag(mag)
  );

  assign edgeHit = (mag > edgeThr);

  // Stage C: fuse edge, motion and border mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outBit <= 1'b0;
    else       outBit <= strobe.interior && edgeHit && chain[C_MID][PIX_W];
  end

  // R6
  motion_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && !strobe.prevOk) |=> !chain[0][PIX_W]);

  // R5
  border_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.interior |=> !outBit);

endmodule

// File: rtl/medge_top.sv
module medge_top
  import medge_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COLS   = 320,
  parameter int ROWS   = 240,
  parameter int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  input  logic [PIX_W-1:0]  inPix,
  input  logic [PIX_W+3:0]  edgeThr,
  input  logic [PIX_W-1:0]  motionThr,
  output logic [ADDR_W-1:0] fsAddr,
  output logic              fsWe,
  output logic [PIX_W-1:0]  fsWrData,
  input  logic [PIX_W-1:0]  fsRdData,
  output logic              outValid,
  output logic              outSof,
  output logic              outEol,
  output logic              outBit
);

  localparam int MAG_W = PIX_W + 4;

  medge_strobe_t strobe;

  assign fsWrData = inPix;

  medge_ctrl #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSof   (inSof),
    .fsAddr  (fsAddr),
    .fsWe    (fsWe),
    .strobe  (strobe),
    .outValid(outValid),
    .outSof  (outSof),
    .outEol  (outEol)
  );

  medge_datapath #(.PIX_W(PIX_W), .COLS(COLS), .MAG_W(MAG_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inPix    (inPix),
    .fsRdData (fsRdData),
    .motionThr(motionThr),
    .edgeThr  (edgeThr),
    .outBit   (outBit)
  );

endmodule

// File: tb/medge_top_tb_top.sv
`timescale 1ns/1ps
module medge_top_tb_top;

  localparam int PW     = 8;
  localparam int COLS   = 10;
  localparam int ROWS   = 8;
  localparam int PIXELS = COLS * ROWS;
  localparam int AW     = $clog2(PIXELS);
  localparam int LAT    = COLS + 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          inValid, inSof;
  logic [PW-1:0] inPix;
  logic [PW+3:0] edgeThr;
  logic [PW-1:0] motionThr;
  logic [AW-1:0] fsAddr;
  logic          fsWe;
  logic [PW-1:0] fsWrData, fsRdData;
  logic          outValid, outSof, outEol, outBit;

  always #2.5 clk = ~clk;

  medge_top #(.PIX_W(PW), .COLS(COLS), .ROWS(ROWS)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inPix(inPix),
    .edgeThr(edgeThr), .motionThr(motionThr), .fsAddr(fsAddr), .fsWe(fsWe),
    .fsWrData(fsWrData), .fsRdData(fsRdData), .outValid(outValid),
    .outSof(outSof), .outEol(outEol), .outBit(outBit)
  );

  // Synchronous store, read before write
  logic [PW-1:0] mem [PIXELS];
  initial for (int i = 0; i < PIXELS; i++) mem[i] = '0;
  always @(posedge clk) begin
    fsRdData <= mem[fsAddr];
    if (fsWe) mem[fsAddr] <= fsWrData;
  end

  typedef struct {
    int b; int sof; int eol; int cyc; int tag;
  } exp_t;

  exp_t expQ[$];
  exp_t got;
  int   curF [PIXELS];
  int   prevRef [PIXELS];
  bit   havePrev = 0;
  int   eThr, mThr;
  int   checks = 0, errors = 0, cycleCnt = 0;
  bit   done = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic string tagName(int t);
    if (t == 5) return "R5";
    if (t == 6) return "R6";
    return "R2/R3/R4";
  endfunction

  function automatic int pv(int r, int c);
    return curF[r*COLS + c];
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // Expected bit and the requirement that decides it
  function automatic int refBit(int r, int c, output int tag);
    int gx, gy, d;
    if (r == 0 || c == 0 || r == ROWS-1 || c == COLS-1) begin tag = 5; return 0; end
    if (!havePrev) begin tag = 6; return 0; end
    tag = 4;
    gx = (pv(r-1,c+1) + 2*pv(r,c+1) + pv(r+1,c+1)) - (pv(r-1,c-1) + 2*pv(r,c-1) + pv(r+1,c-1));
    gy = (pv(r+1,c-1) + 2*pv(r+1,c) + pv(r+1,c+1)) - (pv(r-1,c-1) + 2*pv(r-1,c) + pv(r-1,c+1));
    d  = iabs(pv(r,c) - prevRef[r*COLS + c]);
    return ((iabs(gx) + iabs(gy) > eThr) && (d > mThr)) ? 1 : 0;
  endfunction

  task automatic fillFrame(input bit flat, input int sr, input int sc);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int v;
        v = flat ? 40 : (((r*37 + c*53) ^ (r*c)) & 63);
        if (r >= sr && r < sr + 3 && c >= sc && c < sc + 3) v = 220;
        curF[r*COLS + c] = v;
      end
  endtask

  // Called at a negedge; drives count pixels back to back
  task automatic driveFrame(input int count, input string addrTag);
    int base;
    base = cycleCnt;
    for (int i = 0; i < count; i++) begin
      exp_t e;
      int t;
      e.b   = refBit(i / COLS, i % COLS, t);
      e.tag = t;
      e.sof = (i == 0) ? 1 : 0;
      e.eol = ((i % COLS) == COLS-1) ? 1 : 0;
      e.cyc = base + 1 + i + LAT;
      expQ.push_back(e);
    end
    for (int i = 0; i < count; i++) begin
      inValid = 1'b1;
      inSof   = (i == 0);
      inPix   = PW'(curF[i]);
      #1;
      checks++;
      if (!(fsWe === 1'b1 && int'(fsAddr) == i && fsWrData === PW'(curF[i]))) begin
        errors++;
        $display("FAIL %s store access: actual we=%0b addr=%0d data=%0d expected we=1 addr=%0d data=%0d",
                 (i == 0) ? addrTag : "R7", fsWe, fsAddr, fsWrData, i, curF[i]);
      end
      @(negedge clk);
    end
    inValid = 1'b0;
    inSof   = 1'b0;
    for (int i = 0; i < count; i++) prevRef[i] = curF[i];
    if (count == PIXELS) havePrev = 1;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    inSof   = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop one expected item per output pixel
  always @(negedge clk) begin
    if (rstN && outValid === 1'b1) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected output: actual valid=1 expected none");
      end else begin
        got = expQ.pop_front();
        if (cycleCnt != got.cyc || int'(outSof) != got.sof || int'(outEol) != got.eol) begin
          errors++;
          $display("FAIL R1 timing/flags: actual cyc=%0d sof=%0b eol=%0b expected cyc=%0d sof=%0d eol=%0d",
                   cycleCnt, outSof, outEol, got.cyc, got.sof, got.eol);
        end
        checks++;
        if (int'(outBit) != got.b) begin
          errors++;
          $display("FAIL %s pixel bit: actual %0b expected %0d", tagName(got.tag), outBit, got.b);
        end
      end
    end
  end

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual hung expected done");
      finish();
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inSof = 1'b0; inPix = '0;
    eThr = 100; mThr = 20;
    edgeThr = 12'(eThr); motionThr = 8'(mThr);
    repeat (3) @(negedge clk);
    // R8: outputs quiet under reset
    checks++;
    if (outValid !== 1'b0 || outSof !== 1'b0 || outEol !== 1'b0 || outBit !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset outputs: actual %0b%0b%0b%0b expected 0000", outValid, outSof, outEol, outBit);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R6: first frame yields nothing
    fillFrame(0, 1, 1); driveFrame(PIXELS, "R7");
    idle(4);
    // R2/R3/R4 with moving square; second pair back to back
    fillFrame(0, 2, 3); driveFrame(PIXELS, "R7");
    fillFrame(0, 3, 5); driveFrame(PIXELS, "R7");
    fillFrame(1, 3, 5); driveFrame(PIXELS, "R7");
    idle(LAT + 5);

    // Zero thresholds: strict comparisons matter on flat and unchanged pixels
    eThr = 0; mThr = 0;
    edgeThr = 12'(eThr); motionThr = 8'(mThr);
    fillFrame(1, 3, 5); driveFrame(PIXELS, "R7");
    fillFrame(1, 2, 2); driveFrame(PIXELS, "R7");
    idle(LAT + 5);

    // R9: truncated frame, then a new start of frame right away
    eThr = 100; mThr = 20;
    edgeThr = 12'(eThr); motionThr = 8'(mThr);
    fillFrame(0, 4, 4); driveFrame(5, "R9");
    driveFrame(PIXELS, "R9");
    idle(LAT + 5);

    // R1: every expected output was produced
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1 missing outputs: actual pending=%0d expected 0", expQ.size());
    end
    done = 1;
    finish();
  end

endmodule